// File: doc/BRIEF.md
# UART Interrupt Cause Collector

This block sits beside the receive and transmit buffers of a high-speed UART. It turns their fill counts, the receiver's error pulses and the four modem input pins into five interrupt causes and one interrupt line. The causes are independent sticky flags, so more than one can be pending at once. Software handles every cause it finds set and then clears those flags by writing them back. The block does not encode a single highest-priority cause.

The block holds the cause enables, the receive and transmit trigger-level codes, and a receive character-timeout register. The timeout counts in units of four baud-divisor clocks. The block also keeps sticky line-error and modem-delta flags. It presents the causes, the modem status byte and the line status byte as one 32-bit status word, so a single read returns all three. A status read pulse clears the sticky error and delta flags but leaves the causes pending. All pins are plain control and status pins: no data flows through the block, so it has no valid/ready interface.

Top module: `uart_irq_ident`

## Requirements
- R1: `status_word[4:0]` holds the cause flags: bit 0 is line error, bit 1 is receive level, bit 2 is character timeout, bit 3 is transmit space and bit 4 is modem change. `irq` is high exactly when one or more of these bits is set.
- R2: A cause sets only while its enable is high. The enables are `cfg_en[0]` (receive: levels and timeout), `cfg_en[1]` (transmit space), `cfg_en[2]` (line error) and `cfg_en[3]` (modem change). Conditions that arise while a cause is disabled leave `status_word[4:0]` and `irq` at zero.
- R3: Cause flags are sticky and independent. An `ack_wr` cycle clears the cause bits that are 1 in `ack_mask` and leaves the others pending. If a cause's condition still holds during the clearing cycle, setting wins and the flag stays at 1.
- R4: The receive-level cause sets when `rx_count >= 2^(cfg_rx_trig+2)`. Code 6 (256 bytes) is the reset value.
- R5: The transmit-space cause sets when `DEPTH - tx_count >= 2^(cfg_tx_trig+2)`. Code 5 (128 bytes) is the reset value.
- R6: The character timer runs only while receive is enabled, `rx_count` is nonzero and the timeout register is nonzero. It sets cause bit 2 on the 4*`baud_div`*T-th clock edge after the last `rx_push` or `rx_pop` edge, where T is the register value. It fires once per restart, and each push or pop restarts it.
- R7: Line status byte `status_word[23:16]`: bit 16 is data ready (`rx_count != 0`), bit 17 overrun, bit 18 parity, bit 19 framing, bit 20 break, bit 21 holding empty (`tx_count == 0`), bit 22 transmitter empty (holding empty and not `tx_busy`), bit 23 receive buffer error. The five error bits are sticky until `status_rd`, and any error pulse sets cause bit 0.
- R8: Modem status byte `status_word[15:8]`: bits 12..15 are the synchronized levels of `modem_pins[0..3]` (CTS, DSR, RI, DCD), and bits 8..11 are their sticky change flags, cleared by `status_rd`. Any pin change sets cause bit 4 three clock edges after the pin moves.
- R9: After reset, causes, enables and the timeout register are zero, the trigger codes are tx 5 and rx 6, and status bits [7:5] and [31:24] always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load enables and trigger codes |
| cfg_en | input | 4 | Cause enables (rx, tx space, line error, modem) |
| cfg_tx_trig | input | 3 | Transmit trigger code |
| cfg_rx_trig | input | 3 | Receive trigger code |
| tmo_wr | input | 1 | Load the timeout register |
| tmo_data | input | TMO_W | Timeout in units of 4*baud_div clocks, 0 disables |
| baud_div | input | DIV_W | Baud divisor |
| ack_wr | input | 1 | Cause clear strobe |
| ack_mask | input | 5 | Cause bits to clear |
| status_rd | input | 1 | Status word read; clears sticky error and delta flags |
| rx_count | input | CNT_W | Receive buffer fill count |
| tx_count | input | CNT_W | Transmit buffer fill count |
| rx_push | input | 1 | A byte entered the receive buffer |
| rx_pop | input | 1 | Software released bytes from the receive buffer |
| err_overrun | input | 1 | Overrun pulse |
| err_parity | input | 1 | Parity error pulse |
| err_framing | input | 1 | Framing error pulse |
| err_break | input | 1 | Break detected pulse |
| err_rxbuf | input | 1 | Receive buffer error pulse |
| tx_busy | input | 1 | Transmit shifter holds a character |
| modem_pins | input | 4 | CTS, DSR, RI, DCD levels (bit 0..3) |
| status_word | output | 32 | Causes, modem byte, line byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default DEPTH of 1024, so trigger codes 5 and 6 fall on 128 and 256 bytes, and the boundary counts just below and at each threshold can be driven. It narrows DIV_W and TMO_W to 8 bits and uses a divisor of 2 with a timeout of 3 units. The timer then fires 24 edges after a restart, which puts both the firing edge and a pop-induced restart within a few dozen cycles.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NCAUSE = 5;
  // cause positions in the status word
  localparam int C_LINE = 0;
  localparam int C_RXLV = 1;
  localparam int C_TMO  = 2;
  localparam int C_TXSP = 3;
  localparam int C_MDM  = 4;
  // enable positions
  localparam int EN_RX = 0;
  localparam int EN_TX = 1;
  localparam int EN_LN = 2;
  localparam int EN_MD = 3;

  typedef struct packed {
    logic [2:0] rx_trig;
    logic [2:0] tx_trig;
    logic [3:0] en;
  } irq_cfg_t;

  // trigger code k selects 2^(k+2) bytes
  function automatic int unsigned trig_bytes(input logic [2:0] code);
    return 32'd1 << (int'(code) + 2);
  endfunction
endpackage

// File: rtl/irq_char_timer.sv
module irq_char_timer #(
  parameter int DIV_W = 16,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [TMO_W-1:0] tmo_units,
  output logic             hit
);
  localparam int PRE_W = DIV_W + 2;

  logic [PRE_W-1:0] pre_q;
  logic [TMO_W-1:0] unit_q;
  logic             fired_q;
  logic [PRE_W:0]   limit;
  logic             pre_wrap, last_unit;

  assign limit     = {1'b0, baud_div, 2'b00};
  assign pre_wrap  = ({1'b0, pre_q} + 1'b1) >= limit;
  assign last_unit = unit_q == (tmo_units - 1'b1);
  assign hit       = active && !restart && !fired_q && pre_wrap && last_unit;

  always_ff @(posedge clk) begin
    if (!rst_n || !active || restart) begin
      pre_q   <= '0;
      unit_q  <= '0;
      fired_q <= 1'b0;
    end else if (!fired_q) begin
      if (pre_wrap) begin
        pre_q  <= '0;
        unit_q <= unit_q + 1'b1;
        if (last_unit) fired_q <= 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_modem_track.sv
module irq_modem_track #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic            clr,
  output logic [NPIN-1:0] levels,
  output logic [NPIN-1:0] deltas,
  output logic            changed
);
  logic [NPIN-1:0] chg;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic s1_q, s2_q, prev_q, dlt_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        prev_q <= 1'b0;
        dlt_q  <= 1'b0;
      end else begin
        s1_q   <= pins[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
        dlt_q  <= (dlt_q && !clr) || chg[i];
      end
    end
    assign chg[i]    = s2_q ^ prev_q;
    assign levels[i] = s2_q;
    assign deltas[i] = dlt_q;
  end

  assign changed = |chg;
endmodule

// File: rtl/irq_line_errs.sv
module irq_line_errs #(
  parameter int NERR = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] err_in,
  input  logic            clr,
  output logic [NERR-1:0] err_q,
  output logic            any_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (clr ? '0 : err_q) | err_in;
  end
  assign any_err = |err_in;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DIV_W = 16,
  parameter int TMO_W = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_en,
  input  logic [2:0]       cfg_tx_trig,
  input  logic [2:0]       cfg_rx_trig,
  input  logic             tmo_wr,
  input  logic [TMO_W-1:0] tmo_data,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             ack_wr,
  input  logic [4:0]       ack_mask,
  input  logic             status_rd,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             err_overrun,
  input  logic             err_parity,
  input  logic             err_framing,
  input  logic             err_break,
  input  logic             err_rxbuf,
  input  logic             tx_busy,
  input  logic [3:0]       modem_pins,
  output logic [31:0]      status_word,
  output logic             irq
);
  irq_cfg_t          cfg_q;
  logic [3:0]        en_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [NCAUSE-1:0] cause_q, set_vec, clr_vec;
  logic [4:0]        err_q;
  logic              err_any, tmo_hit, tmr_active, mdm_chg;
  logic [3:0]        mdm_lvl, mdm_dlt;
  logic [31:0]       tx_space;
  logic [7:0]        lsr, msr;
  logic              hold_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{rx_trig: 3'd6, tx_trig: 3'd5, en: 4'd0};
      tmo_q <= '0;
    end else begin
      if (cfg_wr) cfg_q <= '{rx_trig: cfg_rx_trig, tx_trig: cfg_tx_trig, en: cfg_en};
      if (tmo_wr) tmo_q <= tmo_data;
    end
  end
  assign en_q = cfg_q.en;

  irq_line_errs #(.NERR(5)) u_errs (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_in ({err_rxbuf, err_break, err_framing, err_parity, err_overrun}),
    .clr    (status_rd),
    .err_q  (err_q),
    .any_err(err_any)
  );

  irq_modem_track #(.NPIN(4)) u_mdm (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins   (modem_pins),
    .clr    (status_rd),
    .levels (mdm_lvl),
    .deltas (mdm_dlt),
    .changed(mdm_chg)
  );

  assign tmr_active = en_q[EN_RX] && (rx_count != '0) && (tmo_q != '0);

  irq_char_timer #(.DIV_W(DIV_W), .TMO_W(TMO_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (tmr_active),
    .restart  (rx_push || rx_pop),
    .baud_div (baud_div),
    .tmo_units(tmo_q),
    .hit      (tmo_hit)
  );

  assign tx_space = 32'(DEPTH) - 32'(tx_count);

  always_comb begin
    set_vec         = '0;
    set_vec[C_LINE] = en_q[EN_LN] && err_any;
    set_vec[C_RXLV] = en_q[EN_RX] && (32'(rx_count) >= trig_bytes(cfg_q.rx_trig));
    set_vec[C_TMO]  = en_q[EN_RX] && tmo_hit;
    set_vec[C_TXSP] = en_q[EN_TX] && (tx_space >= trig_bytes(cfg_q.tx_trig));
    set_vec[C_MDM]  = en_q[EN_MD] && mdm_chg;
    clr_vec         = ack_wr ? ack_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & ~clr_vec) | set_vec;
  end

  assign hold_empty  = tx_count == '0;
  assign lsr         = {err_q[4], hold_empty && !tx_busy, hold_empty, err_q[3:0], rx_count != '0};
  assign msr         = {mdm_lvl, mdm_dlt};
  assign status_word = {8'h00, lsr, msr, 3'b000, cause_q};
  assign irq         = |cause_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic [4:0]       cause,
  input logic             ack_wr,
  input logic [CNT_W-1:0] rx_count,
  input logic             en_tx,
  input logic             en_md
);
  // R1
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (cause != 5'd0));
  // R2
  txsp_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[3]) |-> $past(en_tx));
  // R2
  mdm_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[4]) |-> $past(en_md));
  // R3
  sticky_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> (($past(cause) & ~cause) == 5'd0));
  // R6
  tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[2]) |-> $past(rx_count != '0));
endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .cause   (status_word[4:0]),
  .ack_wr  (ack_wr),
  .rx_count(rx_count),
  .en_tx   (en_q[1]),
  .en_md   (en_q[3])
);

// File: tb/test_uart_irq_ident.sv
module test_uart_irq_ident;
  localparam int DEPTH = 1024;
  localparam int DIV_W = 8;
  localparam int TMO_W = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, tmo_wr = 0, ack_wr = 0, status_rd = 0;
  logic [3:0] cfg_en = 0;
  logic [2:0] cfg_tx_trig = 3'd5, cfg_rx_trig = 3'd6;
  logic [TMO_W-1:0] tmo_data = 0;
  logic [DIV_W-1:0] baud_div = 8'd2;
  logic [4:0] ack_mask = 0;
  logic [CNT_W-1:0] rx_count = 0, tx_count = 0;
  logic rx_push = 0, rx_pop = 0, tx_busy = 0;
  logic err_overrun = 0, err_parity = 0, err_framing = 0, err_break = 0, err_rxbuf = 0;
  logic [3:0] modem_pins = 0;
  logic [31:0] status_word;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_irq_ident #(.DEPTH(DEPTH), .DIV_W(DIV_W), .TMO_W(TMO_W)) i_uart_irq_ident (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
    .cfg_tx_trig(cfg_tx_trig), .cfg_rx_trig(cfg_rx_trig),
    .tmo_wr(tmo_wr), .tmo_data(tmo_data), .baud_div(baud_div),
    .ack_wr(ack_wr), .ack_mask(ack_mask), .status_rd(status_rd),
    .rx_count(rx_count), .tx_count(tx_count), .rx_push(rx_push), .rx_pop(rx_pop),
    .err_overrun(err_overrun), .err_parity(err_parity), .err_framing(err_framing),
    .err_break(err_break), .err_rxbuf(err_rxbuf), .tx_busy(tx_busy),
    .modem_pins(modem_pins), .status_word(status_word), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [3:0] en, input logic [2:0] txc, input logic [2:0] rxc);
    cfg_en = en; cfg_tx_trig = txc; cfg_rx_trig = rxc; cfg_wr = 1;
    @(negedge clk); cfg_wr = 0;
  endtask

  task automatic ack(input logic [4:0] m);
    ack_mask = m; ack_wr = 1;
    @(negedge clk); ack_wr = 0;
  endtask

  task automatic read_status();
    status_rd = 1;
    @(negedge clk); status_rd = 0;
  endtask

  task automatic t_reset();
    // R9: tx_count 0 and idle shifter give holding and transmitter empty
    check("R9 reset word", status_word, 32'h0060_0000);
    check("R1 reset irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_disabled();
    rx_count = 300; tx_count = 0; err_overrun = 1; modem_pins[2] = 1;
    @(negedge clk); err_overrun = 0;
    wait_n(4);
    check("R2 disabled causes", {27'd0, status_word[4:0]}, 32'd0);
    check("R2 disabled irq", {31'd0, irq}, 32'd0);
    check("R7 overrun latched", {31'd0, status_word[17]}, 32'd1);
    read_status();
    rx_count = 0; tx_count = DEPTH;
    @(negedge clk);
    check("R7 read clears overrun", {31'd0, status_word[17]}, 32'd0);
  endtask

  task automatic t_rxlevel();
    rx_count = 255;
    write_cfg(4'b0001, 3'd5, 3'd6);
    wait_n(2);
    check("R4 below 256", {27'd0, status_word[4:0]}, 32'd0);
    rx_count = 256;
    @(negedge clk);
    check("R4 at 256", {27'd0, status_word[4:0]}, 32'h02);
    check("R1 irq on rx level", {31'd0, irq}, 32'd1);
    ack(5'b00010);
    check("R3 set wins over clear", {27'd0, status_word[4:0]}, 32'h02);
    rx_count = 0;
    ack(5'b00010);
    check("R3 ack clears", {27'd0, status_word[4:0]}, 32'd0);
    check("R1 irq drops", {31'd0, irq}, 32'd0);
    write_cfg(4'b0001, 3'd5, 3'd0);
    rx_count = 3;
    wait_n(2);
    check("R4 code0 below 4", {27'd0, status_word[4:0]}, 32'd0);
    rx_count = 4;
    @(negedge clk);
    check("R4 code0 at 4", {27'd0, status_word[4:0]}, 32'h02);
    rx_count = 0;
    ack(5'b00010);
  endtask

  task automatic t_txspace();
    tx_count = DEPTH - 127;
    write_cfg(4'b0010, 3'd5, 3'd6);
    wait_n(2);
    check("R5 space 127", {27'd0, status_word[4:0]}, 32'd0);
    tx_count = DEPTH - 128;
    @(negedge clk);
    check("R5 space 128", {27'd0, status_word[4:0]}, 32'h08);
    tx_count = DEPTH;
    ack(5'b01000);
    check("R5 cleared when full", {27'd0, status_word[4:0]}, 32'd0);
  endtask

  task automatic t_multi();
    write_cfg(4'b1101, 3'd5, 3'd6);
    err_parity = 1; modem_pins[0] = 1;
    @(negedge clk); err_parity = 0;
    wait_n(2);
    // causes 0 and 4, modem levels CTS+RI with CTS delta, parity bit
    check("R8 R7 multi word", status_word, 32'h0004_5111);
    ack(5'b00001);
    check("R3 other cause kept", {27'd0, status_word[4:0]}, 32'h10);
    read_status();
    check("R8 read clears delta", {24'd0, status_word[15:8]}, 32'h50);
    check("R3 read keeps cause", {27'd0, status_word[4:0]}, 32'h10);
    ack(5'b10000);
    check("R3 ack modem", {27'd0, status_word[4:0]}, 32'd0);
  endtask

  task automatic t_timeout();
    write_cfg(4'b0001, 3'd5, 3'd6);
    tmo_data = 8'd3; tmo_wr = 1;
    @(negedge clk); tmo_wr = 0;
    rx_count = 1; rx_push = 1;
    @(negedge clk); rx_push = 0;
    wait_n(22);
    check("R6 not yet", {27'd0, status_word[4:0]}, 32'd0);
    wait_n(3);
    check("R6 fired", {27'd0, status_word[4:0]}, 32'h04);
    ack(5'b00100);
    wait_n(30);
    check("R6 fires once", {27'd0, status_word[4:0]}, 32'd0);
    rx_push = 1;
    @(negedge clk); rx_push = 0;
    wait_n(14);
    rx_pop = 1;
    @(negedge clk); rx_pop = 0;
    wait_n(22);
    check("R6 pop restarts", {27'd0, status_word[4:0]}, 32'd0);
    wait_n(3);
    check("R6 fired after pop", {27'd0, status_word[4:0]}, 32'h04);
    rx_count = 0;
    ack(5'b00100);
    write_cfg(4'b0000, 3'd5, 3'd6);
  endtask

  task automatic t_line();
    rx_count = 5; tx_count = 0; tx_busy = 1;
    err_overrun = 1; err_framing = 1; err_break = 1; err_rxbuf = 1;
    @(negedge clk);
    err_overrun = 0; err_framing = 0; err_break = 0; err_rxbuf = 0;
    check("R7 line byte", {24'd0, status_word[23:16]}, 32'hBB);
    check("R2 line cause disabled", {27'd0, status_word[4:0]}, 32'd0);
    read_status();
    check("R7 after read", {24'd0, status_word[23:16]}, 32'h21);
    tx_busy = 0;
    @(negedge clk);
    check("R7 transmitter empty", {24'd0, status_word[23:16]}, 32'h61);
    check("R9 reserved bits", {status_word[31:24], 21'd0, status_word[7:5]}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_rxlevel();
    t_txspace();
    t_multi();
    t_timeout();
    t_line();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule